// File: doc/BRIEF.md
# Transmit Status and Interrupt Register

This block holds the command and status word of a serial transmitter. The transmit engine reports events to it as single-cycle pulses: a preamble finished, an idle unit finished, an abort finished, a closing flag or sync finished, a CRC finished, and a character was needed while the FIFO was empty. The block latches each of these in its own sticky flag. Software clears a flag by writing 1 to its bit. The block also shows two live conditions taken straight from the transmitter: the line has drained and the FIFO is empty.

A second register holds one interrupt enable per sticky flag. A single interrupt request is the OR of every set flag whose enable is 1. The idle-sent flag is driven by a small state machine with three states. `ST_LINE_BUSY` means the line is not idling. `ST_IDLE_REPEAT` means a repeating sync or flag pattern is being idled, and the flag re-latches on every unit. `ST_IDLE_SPENT` means a static idle condition has already latched the flag once. The transitions are as follows. `T_GO_REPEAT` goes from busy to repeat when idling starts with select 0. `T_GO_SPENT` goes from busy to spent when idling starts with any other select, and it latches the flag. `T_BACK_BUSY` goes from repeat or spent back to busy when idling ends.

Top module: `txstat_reg`

## Requirements
- R1: After reset every sticky flag, the high byte (bits 15:8) and every interrupt enable read 0, and `irq` is 0.
- R2: With `rd_sel`=0 the read word holds the high byte in bits 15:8: command in 15:12, underrun-wait in 11, idle select in 10:8. Bits 7..0 are preamble, idle, abort, end-of-frame, CRC, all-sent, underrun and FIFO-empty. A status write stores bits 15:8 as written. With `rd_sel`=1 bits 7,6,5,4,3,1 return the stored enables, and every other bit reads 0.
- R3: A status write (`wr_en`=1, `wr_sel`=0) clears each sticky flag whose data bit is 1. A data bit of 0 leaves the flag unchanged.
- R4: The preamble (bit 7), end-of-frame (bit 4) and CRC (bit 3) flags are set by their events only while `sync_mode`=1. The abort flag (bit 5) is set only while `hdlc_mode`=1.
- R5: With idle select 0 (repeating sync/flag), every `idle_unit` pulse while `idle_active`=1 sets bit 6, including a pulse that arrives after the flag was cleared.
- R6: With idle select not 0, bit 6 is set once, in the cycle `idle_active` is first seen high. It is not set again, whatever `idle_unit` does, until `idle_active` has dropped and risen again.
- R7: `ev_need_char` while `fifo_empty`=1 sets the underrun flag (bit 1) in every mode. With `fifo_empty`=0 it has no effect.
- R8: Bit 2 reads the inverse of `char_active`, and bit 0 reads `fifo_empty`, in the same cycle and without latching.
- R9: `irq` is 1 exactly while some sticky flag and its enable are both 1. It stays high until that flag is cleared or its enable is written to 0.
- R10: If a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status word, 1 enable register |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 status word, 1 enable register |
| rd_data | output | 16 | Read data (combinational) |
| sync_mode | input | 1 | Transmitter is in a synchronous mode |
| hdlc_mode | input | 1 | Transmitter is in a bit-oriented framed mode |
| ev_preamble | input | 1 | Pulse: preamble finished |
| ev_abort | input | 1 | Pulse: abort sequence finished |
| ev_closing | input | 1 | Pulse: closing flag or sync finished |
| ev_crc | input | 1 | Pulse: CRC finished |
| ev_need_char | input | 1 | Pulse: engine wants the next character |
| idle_active | input | 1 | Line is in the idle condition |
| idle_unit | input | 1 | Pulse: one idle character or sequence finished |
| char_active | input | 1 | A character is still being shifted out |
| fifo_empty | input | 1 | Transmit FIFO holds no characters |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets set-versus-clear collisions on one flag. A design that lets the clear win would lose the event and read 0. It writes 0 to set flags, where a design that loads instead of clearing would wipe them. For the static idle selects it pulses `idle_unit` repeatedly after a clear. A tracker without the spent state would re-latch the idle flag on every pulse. It also toggles the mode inputs around the synchronous-only and framed-only events, and toggles enables while flags are held, to show that `irq` follows both sides of the AND.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
    localparam int REG_W   = 16;
    localparam int LOW_W   = 8;
    localparam int HIGH_W  = REG_W - LOW_W;
    localparam int SEL_W   = 3;

    localparam int B_PRE   = 7;
    localparam int B_IDLE  = 6;
    localparam int B_ABORT = 5;
    localparam int B_EOF   = 4;
    localparam int B_CRC   = 3;
    localparam int B_ALL   = 2;
    localparam int B_UNDER = 1;
    localparam int B_EMPTY = 0;

    localparam logic [LOW_W-1:0] STICKY_MASK = 8'b1111_1010;
    localparam logic [SEL_W-1:0] SEL_REPEAT  = 3'd0;

    typedef enum logic [1:0] {
        ST_LINE_BUSY   = 2'd0,
        ST_IDLE_REPEAT = 2'd1,
        ST_IDLE_SPENT  = 2'd2
    } idle_st_e;
endpackage

// File: rtl/tx_flag_cell.sv
module tx_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/tx_idle_tracker.sv
module tx_idle_tracker
    import txstat_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle_active,
    input  logic          idle_unit,
    input  logic [SW-1:0] idle_sel,
    output logic          set_o,
    output idle_st_e      state_o
);
    idle_st_e state_q, state_d;
    logic     repeat_sel;

    assign repeat_sel = (idle_sel == SW'(SEL_REPEAT));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LINE_BUSY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        set_o   = 1'b0;
        unique case (state_q)
            ST_LINE_BUSY: begin
                if (idle_active && repeat_sel) begin
                    state_d = ST_IDLE_REPEAT;        // T_GO_REPEAT
                    set_o   = idle_unit;
                end else if (idle_active) begin
                    state_d = ST_IDLE_SPENT;         // T_GO_SPENT
                    set_o   = 1'b1;
                end
            end
            ST_IDLE_REPEAT: begin
                if (!idle_active) state_d = ST_LINE_BUSY;   // T_BACK_BUSY
                else              set_o   = idle_unit;
            end
            ST_IDLE_SPENT: begin
                if (!idle_active) state_d = ST_LINE_BUSY;   // T_BACK_BUSY
            end
            default: state_d = ST_LINE_BUSY;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/txstat_reg.sv
module txstat_reg
    import txstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic              sync_mode,
    input  logic              hdlc_mode,
    input  logic              ev_preamble,
    input  logic              ev_abort,
    input  logic              ev_closing,
    input  logic              ev_crc,
    input  logic              ev_need_char,
    input  logic              idle_active,
    input  logic              idle_unit,
    input  logic              char_active,
    input  logic              fifo_empty,
    output logic              irq
);
    logic [HIGH_W-1:0] high_q;
    logic [LOW_W-1:0]  en_q;
    logic [LOW_W-1:0]  flags;
    logic [LOW_W-1:0]  set_vec;
    logic [LOW_W-1:0]  clr_vec;
    logic              idle_set;
    idle_st_e          idle_state;
    logic              stat_wr;

    assign stat_wr = wr_en && !wr_sel;

    tx_idle_tracker #(.SW(SEL_W)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_active (idle_active),
        .idle_unit   (idle_unit),
        .idle_sel    (high_q[SEL_W-1:0]),
        .set_o       (idle_set),
        .state_o     (idle_state)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[B_PRE]   = ev_preamble && sync_mode;
        set_vec[B_IDLE]  = idle_set;
        set_vec[B_ABORT] = ev_abort && hdlc_mode;
        set_vec[B_EOF]   = ev_closing && sync_mode;
        set_vec[B_CRC]   = ev_crc && sync_mode;
        set_vec[B_UNDER] = ev_need_char && fifo_empty;
        clr_vec          = stat_wr ? wr_data[LOW_W-1:0] : '0;
    end

    for (genvar i = 0; i < LOW_W; i++) begin : g_flag
        if (STICKY_MASK[i]) begin : g_cell
            tx_flag_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (flags[i])
            );
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_q <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel) en_q   <= wr_data[LOW_W-1:0] & STICKY_MASK;
            else        high_q <= wr_data[REG_W-1:LOW_W];
        end
    end

    always_comb begin
        if (rd_sel) begin
            rd_data = {{HIGH_W{1'b0}}, en_q};
        end else begin
            rd_data          = {high_q, flags};
            rd_data[B_ALL]   = !char_active;
            rd_data[B_EMPTY] = fifo_empty;
        end
    end

    assign irq = |(flags & en_q);
endmodule

// File: rtl/txstat_checker.sv
module txstat_checker
    import txstat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic             ev_need_char,
    input logic             fifo_empty,
    input logic             idle_active,
    input logic [LOW_W-1:0] flags,
    input idle_st_e         idle_state,
    input logic             irq
);
    logic [LOW_W-1:0] clr_mask;
    assign clr_mask = (wr_en && !wr_sel) ? (wr_data[LOW_W-1:0] & STICKY_MASK) : '0;

    // R3: flags not targeted by a 1 keep their value
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));

    // R10 / R7: underrun event always lands, even against a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_need_char && fifo_empty) |=> flags[B_UNDER]);

    // R9: request needs a latched flag
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

    // R6: spent state with line still idling never re-latches a cleared idle flag
    a_r6_once_only: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_state == ST_IDLE_SPENT && idle_active && !flags[B_IDLE]) |=> !flags[B_IDLE]);

    // R1: request low right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);
endmodule

bind txstat_reg txstat_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .ev_need_char (ev_need_char),
    .fifo_empty   (fifo_empty),
    .idle_active  (idle_active),
    .flags        (flags),
    .idle_state   (idle_state),
    .irq          (irq)
);

// File: tb/tb_txstat_reg.sv
module tb_txstat_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sync_mode = 0, hdlc_mode = 0;
    logic        ev_preamble = 0, ev_abort = 0, ev_closing = 0, ev_crc = 0, ev_need_char = 0;
    logic        idle_active = 0, idle_unit = 0, char_active = 0, fifo_empty = 0;
    logic        irq;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    txstat_reg dut (.*);

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0; wr_data = '0;
    endtask

    task automatic clear_all();
        wr(1'b0, {rd_hi(), 8'hFF});
    endtask

    function automatic logic [7:0] rd_hi();
        return dut.rd_sel ? 8'h00 : rd_data[15:8];
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        char_active = 1; fifo_empty = 0;
        rd(0, v); chk("R1 status", v, 16'h0000);
        rd(1, v); chk("R1 enables", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_layout();
        logic [15:0] v;
        wr(0, 16'hA500);
        rd(0, v); chk("R2 high byte", v & 16'hFF00, 16'hA500);
        wr(1, 16'hFFFF);
        rd(1, v); chk("R2 enable readback", v, 16'h00FA);
        wr(1, 16'h0000);
        wr(0, 16'h0000);
    endtask

    task automatic t_live();
        logic [15:0] v;
        char_active = 0; fifo_empty = 1;
        rd(0, v); chk("R8 live bits", v & 16'h0005, 16'h0005);
        char_active = 1; fifo_empty = 0;
        rd(0, v); chk("R8 live bits low", v & 16'h0005, 16'h0000);
    endtask

    task automatic t_modes();
        logic [15:0] v;
        sync_mode = 0; hdlc_mode = 0;
        @(negedge clk); ev_preamble = 1; ev_closing = 1; ev_crc = 1; ev_abort = 1;
        @(negedge clk); ev_preamble = 0; ev_closing = 0; ev_crc = 0; ev_abort = 0;
        rd(0, v); chk("R4 async ignores", v & 16'h00B8, 16'h0000);
        sync_mode = 1;
        @(negedge clk); ev_preamble = 1; ev_closing = 1; ev_crc = 1; ev_abort = 1;
        @(negedge clk); ev_preamble = 0; ev_closing = 0; ev_crc = 0; ev_abort = 0;
        rd(0, v); chk("R4 sync sets", v & 16'h00B8, 16'h0098);
        hdlc_mode = 1;
        @(negedge clk); ev_abort = 1;
        @(negedge clk); ev_abort = 0;
        rd(0, v); chk("R4 framed abort", v & 16'h00B8, 16'h00B8);
        wr(0, 16'h0010);
        rd(0, v); chk("R3 one clears only bit4", v & 16'h00B8, 16'h00A8);
        wr(0, 16'h0000);
        rd(0, v); chk("R3 zero write keeps", v & 16'h00B8, 16'h00A8);
        wr(0, 16'h00FF);
        rd(0, v); chk("R3 clear all", v & 16'h00FA, 16'h0000);
        sync_mode = 0; hdlc_mode = 0;
    endtask

    task automatic t_underrun();
        logic [15:0] v;
        fifo_empty = 0;
        @(negedge clk); ev_need_char = 1;
        @(negedge clk); ev_need_char = 0;
        rd(0, v); chk("R7 fifo not empty", v & 16'h0002, 16'h0000);
        fifo_empty = 1;
        @(negedge clk); ev_need_char = 1;
        @(negedge clk); ev_need_char = 0;
        rd(0, v); chk("R7 async underrun", v & 16'h0002, 16'h0002);
        @(negedge clk); ev_need_char = 1; wr_en = 1; wr_sel = 0; wr_data = 16'h0002;
        @(negedge clk); ev_need_char = 0; wr_en = 0; wr_data = '0;
        rd(0, v); chk("R10 set beats clear", v & 16'h0002, 16'h0002);
        wr(0, 16'h0002);
        rd(0, v); chk("R3 underrun cleared", v & 16'h0002, 16'h0000);
        fifo_empty = 0;
    endtask

    task automatic t_idle_repeat();
        logic [15:0] v;
        wr(0, 16'h0000);
        @(negedge clk); idle_active = 1;
        @(negedge clk);
        rd(0, v); chk("R5 no unit yet", v & 16'h0040, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); idle_unit = 1;
            @(negedge clk); idle_unit = 0;
            rd(0, v); chk("R5 unit latches", v & 16'h0040, 16'h0040);
            wr(0, 16'h0040);
            rd(0, v); chk("R5 cleared", v & 16'h0040, 16'h0000);
        end
        @(negedge clk); idle_active = 0;
        @(negedge clk);
    endtask

    task automatic t_idle_once();
        logic [15:0] v;
        wr(0, 16'h0300);
        @(negedge clk); idle_active = 1;
        @(negedge clk);
        rd(0, v); chk("R6 first bit", v & 16'h0040, 16'h0040);
        wr(0, 16'h0340);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); idle_unit = 1;
            @(negedge clk); idle_unit = 0;
        end
        rd(0, v); chk("R6 no relatch", v & 16'h0040, 16'h0000);
        @(negedge clk); idle_active = 0;
        @(negedge clk); idle_active = 1;
        @(negedge clk);
        rd(0, v); chk("R6 new idle period", v & 16'h0040, 16'h0040);
        idle_active = 0;
        wr(0, 16'h0040);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        sync_mode = 1;
        @(negedge clk); ev_crc = 1;
        @(negedge clk); ev_crc = 0;
        #1; chk("R9 flag no enable", {15'd0, irq}, 16'h0000);
        wr(1, 16'h0008);
        #1; chk("R9 enabled flag", {15'd0, irq}, 16'h0001);
        wr(0, 16'h0080);
        #1; chk("R9 other clear keeps irq", {15'd0, irq}, 16'h0001);
        wr(1, 16'h0000);
        #1; chk("R9 enable dropped", {15'd0, irq}, 16'h0000);
        wr(1, 16'h0008);
        #1; chk("R9 re-enabled", {15'd0, irq}, 16'h0001);
        wr(0, 16'h0008);
        #1; chk("R9 cleared", {15'd0, irq}, 16'h0000);
        rd(0, v); chk("R9 crc flag gone", v & 16'h0008, 16'h0000);
        sync_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_live();
        t_modes();
        t_underrun();
        t_idle_repeat();
        t_idle_once();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule